// File: doc/BRIEF.md
# RTC Alarm Compare and Flag Unit

This block sits next to the calendar and time counters of a real-time clock. It holds six alarm registers, one each for seconds, minutes, hours, weekday, day of month and month. Bit 7 of each alarm register is an enable bit. The block compares every enabled register with its counter. When all enabled fields match, it raises an alarm flag. A control register holds that alarm flag, a carry flag set by an external carry strobe, and one interrupt enable for each flag. Each interrupt output is a flag gated by its enable.

Two resets are provided. The asynchronous power-on reset clears every enable bit and the whole control register. The synchronous manual reset keeps all alarm registers as they are, clears the control register, and leaves the carry flag alone. A small edge-detect state machine raises the alarm flag once for each new match. It has two states. ST_WAIT means no match has been seen. ST_HELD means the current match has already been reported. The transition WAIT->HELD happens when the match condition becomes true, and it emits the set pulse. The transition HELD->WAIT happens when the match drops. Power-on reset enters ST_WAIT. Software clears a flag by writing 0 to it. Hardware may set a flag between a software read and a later write, so software should not use read-modify-write on the control register.

Top module: `rtc_alarm_unit`

## Requirements
- R1: Addresses 0 to 5 select the seconds, minutes, hours, weekday, day and month alarm registers. A write stores the byte and a read returns it. Bit 7 is the enable bit. In the month register, bits 6:5 always read 0.
- R2: After power-on reset, bit 7 of every alarm register reads 0, the control register at address 6 reads 0x00, and both interrupt outputs are low.
- R3: While manual reset is high, register writes are ignored. Alarm registers keep their value and their enable bit. In the control register, the interrupt enables and the alarm flag clear, and the carry flag keeps its value.
- R4: Each enabled field is compared on bits 6:0 (bits 4:0 for month) against the same bits of its counter. Counter bit 7, month bits 6:5 and disabled fields do not affect the result. When every enabled field matches, the alarm flag reads 1 after the next clock edge.
- R5: If no alarm register is enabled, the alarm flag is never set.
- R6: The alarm flag is set only when the match condition becomes true. If software clears the flag while the match persists, the flag stays clear. A new match after a mismatch sets it again.
- R7: The control register is at address 6. Bit 7 is the carry flag, bit 4 the carry interrupt enable, bit 3 the alarm interrupt enable and bit 0 the alarm flag. Bits 6, 5, 2 and 1 read 0. The two enables take the written value.
- R8: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged.
- R9: If a hardware set and a software clear of the same flag happen in the same cycle, the flag ends up set.
- R10: A one-cycle high on carry_stb sets the carry flag at that clock edge.
- R11: alarm_irq is high exactly when the alarm flag and the alarm interrupt enable are both 1. carry_irq is high exactly when the carry flag and the carry interrupt enable are both 1.
- R12: Address 7 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mrst | input | 1 | Synchronous manual reset, active high |
| carry_stb | input | 1 | Carry event strobe, sets the carry flag |
| cnt_sec | input | 8 | BCD seconds counter |
| cnt_min | input | 8 | BCD minutes counter |
| cnt_hour | input | 8 | BCD hours counter |
| cnt_wday | input | 8 | Weekday counter |
| cnt_mday | input | 8 | BCD day-of-month counter |
| cnt_mon | input | 8 | BCD month counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| alarm_irq | output | 1 | Alarm interrupt request |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The bench goes after the following corner cases.

- **Mixed enables and masked bits.** Random mixes of enabled and disabled fields are checked together with random junk in the ignored counter bits. A compare that included disabled fields or masked bits would miss alarms or report false ones.
- **Persistent match.** Software clears the alarm flag while the match is still true. A level-sensitive flag would come straight back.
- **Same-cycle set and clear.** A hardware set and a software clear of the same flag land in the same cycle. A design that let the write win would lose the event.
- **Manual reset.** A write is attempted during manual reset. A design that reset the carry flag, the enables or the alarm values, or that accepted the write, would show it on readback.
- **No enable.** With every enable off and the counters equal to the alarm values, a design that treated an empty set as a match would raise the alarm.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int VAL_W      = DATA_W - 1;
    localparam int EN_BIT     = DATA_W - 1;
    localparam int MON_IDX    = 5;

    localparam int CF_BIT  = 7;
    localparam int CIE_BIT = 4;
    localparam int AIE_BIT = 3;
    localparam int AF_BIT  = 0;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_HELD = 1'b1
    } edge_state_t;

    // Value bits that take part in storage and comparison for each field.
    function automatic logic [VAL_W-1:0] field_mask(input int idx);
        return (idx == MON_IDX) ? VAL_W'(7'h1F) : {VAL_W{1'b1}};
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       mrst,
    input  logic                       wr,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [NF-1:0]              en,
    output logic [NF-1:0][DW-2:0]      val
);

    localparam int VW = DW - 1;

    for (genvar g = 0; g < NF; g++) begin : g_field
        logic          sel;
        logic          en_q;
        logic [VW-1:0] val_q;

        assign sel = wr && !mrst && (addr == AW'(g));

        // Enable bit: cleared only by power-on reset.
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                en_q <= 1'b0;
            end else if (sel) begin
                en_q <= wdata[DW-1];
            end
        end

        // Value field: never reset, kept through manual reset.
        always_ff @(posedge clk) begin
            if (sel) begin
                val_q <= wdata[VW-1:0] & field_mask(g);
            end
        end

        assign en[g]  = en_q;
        assign val[g] = val_q;
    end

    // R3
    en_hold_mrst_chk: assert property (@(posedge clk) disable iff (!por_n)
        mrst |=> (en == $past(en)));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = DATA_W
) (
    input  logic [NF-1:0]          en,
    input  logic [NF-1:0][DW-2:0]  val,
    input  logic [NF-1:0][DW-1:0]  cnt,
    output logic                   any_en,
    output logic                   match
);

    logic [NF-1:0] hit;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        assign hit[g] = !en[g] || (val[g] == (cnt[g][DW-2:0] & field_mask(g)));
    end

    assign any_en = |en;
    assign match  = any_en && (&hit);

endmodule

// File: rtl/rtc_alarm_edge_fsm.sv
module rtc_alarm_edge_fsm
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic match,
    output logic set_pulse
);

    edge_state_t state_q;
    edge_state_t state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        set_pulse = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (match) begin
                    state_d   = ST_HELD;
                    set_pulse = 1'b1;
                end
            end
            ST_HELD: begin
                if (!match) begin
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // R6
    set_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        set_pulse |=> !set_pulse);

endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_alarm_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          mrst,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    input  logic          alarm_set,
    input  logic          carry_set,
    output logic          cf,
    output logic          cie,
    output logic          aie,
    output logic          af
);

    logic wr_eff;
    assign wr_eff = wr_ctrl && !mrst;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cf  <= 1'b0;
            cie <= 1'b0;
            aie <= 1'b0;
            af  <= 1'b0;
        end else if (mrst) begin
            cf  <= cf | carry_set;
            cie <= 1'b0;
            aie <= 1'b0;
            af  <= alarm_set;
        end else begin
            cf <= carry_set | (cf & !(wr_eff && !wdata[CF_BIT]));
            af <= alarm_set | (af & !(wr_eff && !wdata[AF_BIT]));
            if (wr_eff) begin
                cie <= wdata[CIE_BIT];
                aie <= wdata[AIE_BIT];
            end
        end
    end

    // R9
    af_set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        alarm_set |=> af);

    // R10
    cf_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        carry_set |=> cf);

    // R8
    af_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_ctrl && !mrst && !wdata[AF_BIT] && !alarm_set) |=> !af);

    // R3
    cf_mrst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mrst && !carry_set) |=> (cf == $past(cf)));

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        mrst,
    input  logic        carry_stb,
    input  logic [7:0]  cnt_sec,
    input  logic [7:0]  cnt_min,
    input  logic [7:0]  cnt_hour,
    input  logic [7:0]  cnt_wday,
    input  logic [7:0]  cnt_mday,
    input  logic [7:0]  cnt_mon,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        alarm_irq,
    output logic        carry_irq
);

    localparam int NF = NUM_FIELDS;
    localparam int DW = DATA_W;

    logic [NF-1:0]          en;
    logic [NF-1:0][DW-2:0]  val;
    logic [NF-1:0][DW-1:0]  cnt;
    logic                   any_en;
    logic                   match;
    logic                   set_pulse;
    logic                   cf, cie, aie, af;

    assign cnt = {cnt_mon, cnt_mday, cnt_wday, cnt_hour, cnt_min, cnt_sec};

    rtc_alarm_regs #(.NF(NF), .DW(DW), .AW(ADDR_W)) u_regs (
        .clk   (clk),
        .por_n (por_n),
        .mrst  (mrst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .en    (en),
        .val   (val)
    );

    rtc_alarm_match #(.NF(NF), .DW(DW)) u_match (
        .en     (en),
        .val    (val),
        .cnt    (cnt),
        .any_en (any_en),
        .match  (match)
    );

    rtc_alarm_edge_fsm u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .match     (match),
        .set_pulse (set_pulse)
    );

    rtc_ctrl_reg #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .mrst      (mrst),
        .wr_ctrl   (reg_wr && (reg_addr == CTRL_ADDR)),
        .wdata     (reg_wdata),
        .alarm_set (set_pulse),
        .carry_set (carry_stb),
        .cf        (cf),
        .cie       (cie),
        .aie       (aie),
        .af        (af)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < ADDR_W'(NF)) begin
            reg_rdata = {en[reg_addr], val[reg_addr]};
        end else if (reg_addr == CTRL_ADDR) begin
            reg_rdata[CF_BIT]  = cf;
            reg_rdata[CIE_BIT] = cie;
            reg_rdata[AIE_BIT] = aie;
            reg_rdata[AF_BIT]  = af;
        end
    end

    assign alarm_irq = af & aie;
    assign carry_irq = cf & cie;

    // R5
    no_enable_no_alarm_chk: assert property (@(posedge clk) disable iff (!por_n)
        !any_en |-> !set_pulse);

endmodule

// File: tb/tb_rtc_alarm_unit.sv
module tb_rtc_alarm_unit;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mrst = 1'b0;
    logic       carry_stb = 1'b0;
    logic [7:0] cnt [6];
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       alarm_irq;
    logic       carry_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic       sh_en  [6];
    logic [6:0] sh_val [6];

    always #4 clk = ~clk;

    rtc_alarm_unit dut (
        .clk       (clk),
        .por_n     (por_n),
        .mrst      (mrst),
        .carry_stb (carry_stb),
        .cnt_sec   (cnt[0]),
        .cnt_min   (cnt[1]),
        .cnt_hour  (cnt[2]),
        .cnt_wday  (cnt[3]),
        .cnt_mday  (cnt[4]),
        .cnt_mon   (cnt[5]),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .alarm_irq (alarm_irq),
        .carry_irq (carry_irq)
    );

    function automatic logic [6:0] fmask(input int i);
        return (i == 5) ? 7'h1F : 7'h7F;
    endfunction

    function automatic logic exp_match();
        logic any = 1'b0;
        logic all = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (sh_en[i]) begin
                any = 1'b1;
                if ((cnt[i][6:0] & fmask(i)) != sh_val[i]) all = 1'b0;
            end
        end
        return any && all;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr_alarm(input int i, input logic [7:0] d);
        wr(3'(i), d);
        sh_en[i]  = d[7];
        sh_val[i] = d[6:0] & fmask(i);
    endtask

    task automatic set_mismatch();
        @(negedge clk);
        for (int i = 0; i < 6; i++) cnt[i] = {1'b0, sh_val[i] ^ 7'h01};
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        logic       e;
        void'($urandom(32'd1234));
        for (int i = 0; i < 6; i++) begin
            cnt[i] = 8'h00; sh_en[i] = 1'b0; sh_val[i] = 7'h0;
        end
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R2: power-on state
        rd(3'd6, d); chk("R2 ctrl", d, 8'h00);
        chk("R2 irqs", {alarm_irq, carry_irq}, 2'b00);
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), d); chk("R2 enable", d[7], 1'b0);
        end

        // R1: alarm register readback, month bits 6:5 masked
        for (int i = 0; i < 6; i++) begin
            v = 8'($urandom) & 8'h7F;
            if (i == 5) v = v | 8'h60;
            wr_alarm(i, v);
            rd(3'(i), d); chk("R1 readback", d, {1'b0, sh_val[i]});
        end
        wr_alarm(0, 8'hA5);
        rd(3'd0, d); chk("R1 enable bit", d, 8'hA5);

        // R12: unused address
        wr(3'd7, 8'hFF);
        rd(3'd7, d); chk("R12 read zero", d, 8'h00);
        rd(3'd0, d); chk("R12 no side effect", d, 8'hA5);
        wr_alarm(0, 8'h25);

        // R7: layout, reserved bits, writable enables
        wr(3'd6, 8'hFF);
        rd(3'd6, d); chk("R7 enables set, flags kept", d, 8'h18);
        wr(3'd6, 8'h08);
        rd(3'd6, d); chk("R7 cie clear", d, 8'h08);

        // R10 / R11: carry flag and interrupt
        @(negedge clk); carry_stb = 1'b1;
        @(negedge clk); carry_stb = 1'b0;
        rd(3'd6, d); chk("R10 carry set", d, 8'h88);
        chk("R11 carry_irq masked", carry_irq, 1'b0);
        wr(3'd6, 8'h98);
        chk("R11 carry_irq", carry_irq, 1'b1);
        rd(3'd6, d); chk("R8 write 1 keeps cf", d, 8'h98);
        wr(3'd6, 8'h18);
        rd(3'd6, d); chk("R8 write 0 clears cf", d, 8'h18);

        // R9: carry strobe wins over clear
        @(negedge clk); carry_stb = 1'b1;
        @(negedge clk); carry_stb = 1'b0;
        @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h18; carry_stb = 1'b1;
        @(negedge clk); reg_wr = 1'b0; carry_stb = 1'b0;
        rd(3'd6, d); chk("R9 cf set wins", d[7], 1'b1);
        wr(3'd6, 8'h18);

        // R5: no enables, counters equal values
        for (int i = 0; i < 6; i++) wr_alarm(i, {1'b0, 7'($urandom)});
        set_mismatch();
        @(negedge clk);
        for (int i = 0; i < 6; i++) cnt[i] = {1'b0, sh_val[i]};
        repeat (2) @(negedge clk);
        rd(3'd6, d); chk("R5 no enable no alarm", d[0], 1'b0);

        // R4 / R11: random enables and counters
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 6; i++) begin
                v = 8'($urandom);
                if (i == 5) v[4:0] = 5'($urandom_range(1, 12));
                wr_alarm(i, v);
            end
            set_mismatch();
            wr(3'd6, 8'h18);
            @(negedge clk);
            for (int i = 0; i < 6; i++) begin
                if ($urandom_range(0, 3) != 0) begin
                    v = 8'($urandom);
                    cnt[i] = {v[7], (sh_val[i] | (v[6:0] & ~fmask(i)))};
                end else begin
                    cnt[i] = 8'($urandom);
                end
            end
            e = exp_match();
            @(negedge clk);
            chk("R4 alarm flag", alarm_irq, e);
            rd(3'd6, d); chk("R4 flag bit", d[0], e);
        end

        // R6: persistent match, rearm
        wr_alarm(0, 8'h80 | 8'h33);
        for (int i = 1; i < 6; i++) wr_alarm(i, 8'h01);
        set_mismatch();
        wr(3'd6, 8'h18);
        @(negedge clk); cnt[0] = 8'h33;
        @(negedge clk);
        chk("R6 first match", alarm_irq, 1'b1);
        wr(3'd6, 8'h18);
        repeat (3) @(negedge clk);
        chk("R6 no reset while held", alarm_irq, 1'b0);
        cnt[0] = 8'h34;
        @(negedge clk); cnt[0] = 8'h33;
        @(negedge clk);
        chk("R6 rearm", alarm_irq, 1'b1);

        // R9: alarm set wins over same-cycle clear
        set_mismatch();
        wr(3'd6, 8'h18);
        @(negedge clk);
        cnt[0] = 8'h33; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h18;
        @(negedge clk); reg_wr = 1'b0;
        chk("R9 af set wins", alarm_irq, 1'b1);

        // R3: manual reset
        @(negedge clk); carry_stb = 1'b1;
        @(negedge clk); carry_stb = 1'b0;
        set_mismatch();
        @(negedge clk);
        mrst = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00;
        @(negedge clk);
        mrst = 1'b0; reg_wr = 1'b0;
        rd(3'd6, d); chk("R3 ctrl after manual reset", d, 8'h80);
        rd(3'd0, d); chk("R3 alarm kept", d, 8'hB3);
        rd(3'd1, d); chk("R3 enable kept", d, 8'h01);

        done = 1'b1;
        report();
    end

endmodule